// File: doc/BRIEF.md
# Fetch Group Extractor

This block takes one instruction-cache line and cuts from it the group of instructions that a thread hands to decode in one cycle. It keeps the thread's current and next program counters. Each accepted request starts at the word the current PC selects, walks forward through the line, and fills up to `FETCH_W` output slots. Each slot carries the instruction word, its PC, its predicted next PC and a predicted-taken bit. All instructions are 4 bytes. There are no delay slots and no micro-op expansion.

A predecode and prediction stage sits beside the block. For each group position it supplies whether the instruction is a control transfer, whether it is predicted taken, its predicted target, and whether it is a quiesce instruction. A group ends at the first of these: the fetch width, the end of the line, or an instruction whose predicted successor is not the next word. A quiesce instruction also ends the group. A translation fault replaces the whole group with a single no-op that carries the fault. The fault also leaves the stored PC pair untouched and parks the thread until a redirect. Three saturating counters record instructions, branches and predicted-taken branches.

Top module: `fetch_group_extractor`

## Requirements
- R1: After reset, `cur_pc` is 0, `cur_npc` is 4, `out_valid`, `out_mask`, `out_count`, both pending flags and all three counters are 0.
- R2: The first slot takes the line word at index (`cur_pc` mod `LINE_BYTES`) / 4, the two low PC bits being ignored. Slot k takes the word k positions after it. Word j of the line is `line_data[32*j +: 32]`.
- R3: A group holds no more than `FETCH_W` slots and no word past the end of the line.
- R4: A non-control slot predicts next PC = the running NPC and moves NPC forward by 4. Its taken bit is 0.
- R5: A control slot predicts next PC = its target when predicted taken, else its PC + 4. The running NPC becomes that value + 4. Its taken bit equals the prediction.
- R6: After a group without fault, `cur_pc`/`cur_npc` hold the running PC/NPC that follow the last emitted slot. The group stops after any slot whose predicted next PC differs from its PC + 4.
- R7: With `fetch_fault` set, an accepted request emits one slot: word `NOP_WORD`, slot PC = `cur_pc`, predicted next = `cur_npc`, `out_fault` = 1. It sets `trap_pending` and leaves `cur_pc`/`cur_npc` unchanged.
- R8: A slot flagged quiesce is emitted, ends the group and sets `quiesce_pending`.
- R9: Outputs are registered. `out_valid` pulses in the cycle after an accepted request. A request is ignored while either pending flag is set or `redir_valid` is high. A redirect loads `cur_pc`/`cur_npc` and clears both pending flags.
- R10: `cnt_inst` adds the slots of each non-fault group, `cnt_branch` its control slots, and `cnt_taken` its predicted-taken control slots. Each counter saturates at 2^`CNT_W`-1.
- R11: `out_mask` sets bits 0..`out_count`-1 only. Slots outside the mask, and all group outputs when `out_valid` is 0, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| redir_valid | input | 1 | Load a new PC pair |
| redir_pc | input | ADDR_W | PC to load |
| redir_npc | input | ADDR_W | NPC to load |
| grp_req | input | 1 | Extract a group from `line_data` this cycle |
| line_data | input | 8*LINE_BYTES | Cache line, word j at bits 32*j upward |
| fetch_fault | input | 1 | Translation of this fetch faulted |
| slot_is_ctrl | input | FETCH_W | Per group position: control instruction |
| slot_pred_taken | input | FETCH_W | Per group position: predicted taken |
| slot_pred_tgt | input | FETCH_W*ADDR_W | Per group position: predicted target |
| slot_is_quiesce | input | FETCH_W | Per group position: quiesce instruction |
| out_valid | output | 1 | Group present this cycle |
| out_mask | output | FETCH_W | Valid slots |
| out_count | output | $clog2(FETCH_W+1) | Number of valid slots |
| out_inst | output | FETCH_W*32 | Instruction words |
| out_pc | output | FETCH_W*ADDR_W | Slot PCs |
| out_next_pc | output | FETCH_W*ADDR_W | Predicted next PC per slot |
| out_taken | output | FETCH_W | Predicted-taken bit per slot |
| out_fault | output | 1 | Group is a fault-carrying no-op |
| cur_pc | output | ADDR_W | Stored PC |
| cur_npc | output | ADDR_W | Stored NPC |
| trap_pending | output | 1 | Thread parked on a fault |
| quiesce_pending | output | 1 | Thread parked on a quiesce |
| cnt_inst | output | CNT_W | Instructions fetched |
| cnt_branch | output | CNT_W | Control instructions fetched |
| cnt_taken | output | CNT_W | Predicted-taken branches fetched |

## Verification
Several group-ending causes can fall on the same slot. A predicted-taken branch can be the last word of the line and also fill the fetch width. A quiesce can sit on a taken branch. A redirect can arrive with a request in the same cycle. Directed cases place a taken target on the last line word at full width and pair redirect with request. A long random run also mixes these causes. A behavioural model in the bench judges every cycle. It walks the line with plain integers and compares slot count, mask, every slot field, the PC pair, the pending flags and the counters.

// File: rtl/fge_pkg.sv
// Shared constants for the fetch group extractor.
// Assumes fixed 4-byte instructions.
package fge_pkg;
    localparam int INST_BYTES = 4;
    localparam int INST_BITS  = 32;
endpackage

// File: rtl/fge_word_select.sv
// Picks, for each group position, the line word at start index + position.
// Assumes LINE_BYTES/4 is a power of two and FETCH_W <= LINE_BYTES/4.
module fge_word_select #(
    parameter int LINE_BYTES = 32,
    parameter int FETCH_W    = 4,
    localparam int IW        = fge_pkg::INST_BITS,
    localparam int WORDS     = LINE_BYTES / fge_pkg::INST_BYTES,
    localparam int IDX_W     = $clog2(WORDS)
) (
    input  logic [LINE_BYTES*8-1:0] line_data,
    input  logic [IDX_W-1:0]        start_idx,
    output logic [FETCH_W*IW-1:0]   slot_word,
    output logic [FETCH_W-1:0]      slot_in_line
);
    logic [IW-1:0] words [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_split
        assign words[w] = line_data[w*IW +: IW];
    end

    for (genvar s = 0; s < FETCH_W; s++) begin : g_slot
        logic [IDX_W:0] pos;
        // purpose: locate the line word feeding group position s
        always_comb begin
            pos = {1'b0, start_idx} + (IDX_W+1)'(s);
            slot_in_line[s] = pos < (IDX_W+1)'(WORDS);
            slot_word[s*IW +: IW] = slot_in_line[s] ? words[pos[IDX_W-1:0]] : '0;
        end
    end
endmodule

// File: rtl/fge_slot_walker.sv
// Walks the group positions in order, producing slot PCs, predicted next PCs,
// the emit mask and the final PC pair. Stops after the line end, a
// non-sequential successor or a quiesce instruction. Purely combinational.
module fge_slot_walker #(
    parameter int FETCH_W = 4,
    parameter int ADDR_W  = 32,
    localparam int CW     = $clog2(FETCH_W+1)
) (
    input  logic [ADDR_W-1:0]         pc,
    input  logic [ADDR_W-1:0]         npc,
    input  logic [FETCH_W-1:0]        in_line,
    input  logic [FETCH_W-1:0]        is_ctrl,
    input  logic [FETCH_W-1:0]        pred_taken,
    input  logic [FETCH_W*ADDR_W-1:0] pred_tgt,
    input  logic [FETCH_W-1:0]        is_quiesce,
    output logic [FETCH_W-1:0]        emit_mask,
    output logic [FETCH_W*ADDR_W-1:0] slot_pc,
    output logic [FETCH_W*ADDR_W-1:0] slot_next,
    output logic [FETCH_W-1:0]        slot_taken,
    output logic [ADDR_W-1:0]         final_pc,
    output logic [ADDR_W-1:0]         final_npc,
    output logic                      hit_quiesce,
    output logic [CW-1:0]             n_emit,
    output logic [CW-1:0]             n_branch,
    output logic [CW-1:0]             n_taken
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(fge_pkg::INST_BYTES);

    logic [ADDR_W-1:0] cur, cn, nx, nn;
    logic              alive;

    // purpose: sequential next-PC walk across the group positions
    always_comb begin
        cur = pc;
        cn = npc;
        nx = '0;
        nn = '0;
        alive = 1'b1;
        emit_mask = '0;
        slot_pc = '0;
        slot_next = '0;
        slot_taken = '0;
        hit_quiesce = 1'b0;
        n_emit = '0;
        n_branch = '0;
        n_taken = '0;
        for (int i = 0; i < FETCH_W; i++) begin
            if (alive && in_line[i]) begin
                if (is_ctrl[i]) begin
                    nx = pred_taken[i] ? pred_tgt[i*ADDR_W +: ADDR_W] : cur + STEP;
                    nn = nx + STEP;
                    slot_taken[i] = pred_taken[i];
                    n_branch = n_branch + CW'(1);
                    if (pred_taken[i]) n_taken = n_taken + CW'(1);
                end else begin
                    nx = cn;
                    nn = cn + STEP;
                end
                emit_mask[i] = 1'b1;
                slot_pc[i*ADDR_W +: ADDR_W] = cur;
                slot_next[i*ADDR_W +: ADDR_W] = nx;
                n_emit = n_emit + CW'(1);
                if (is_quiesce[i]) hit_quiesce = 1'b1;
                alive = (nx == cur + STEP) && !is_quiesce[i];
                cur = nx;
                cn = nn;
            end else begin
                alive = 1'b0;
            end
        end
        final_pc = cur;
        final_npc = cn;
    end
endmodule

// File: rtl/fge_sat_counter.sv
// Event counter that adds a small increment each cycle and sticks at all-ones.
module fge_sat_counter #(
    parameter int CNT_W = 16,
    parameter int INC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W:0] sum;

    // purpose: widened sum so overflow is visible
    always_comb sum = {1'b0, count} + (CNT_W+1)'(inc);

    // purpose: accumulate with saturation
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (sum[CNT_W]) count <= '1;
        else              count <= sum[CNT_W-1:0];
    end
endmodule

// File: rtl/fetch_group_extractor.sv
// Fetch group extractor: holds one thread's PC/NPC, cuts a group of up to
// FETCH_W 4-byte instructions from a supplied cache line per accepted
// request, and registers the group for decode. A fault turns the group into
// one no-op and parks the thread; a quiesce also parks it; a redirect
// reloads the PC pair and releases it.
// Assumes the supplied line is the one containing cur_pc.
module fetch_group_extractor #(
    parameter int          LINE_BYTES = 32,
    parameter int          FETCH_W    = 4,
    parameter int          ADDR_W     = 32,
    parameter int          CNT_W      = 16,
    parameter logic [31:0] NOP_WORD   = 32'h0000_0013,
    localparam int IW    = fge_pkg::INST_BITS,
    localparam int WORDS = LINE_BYTES / fge_pkg::INST_BYTES,
    localparam int IDX_W = $clog2(WORDS),
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int CW    = $clog2(FETCH_W+1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      redir_valid,
    input  logic [ADDR_W-1:0]         redir_pc,
    input  logic [ADDR_W-1:0]         redir_npc,
    input  logic                      grp_req,
    input  logic [LINE_BYTES*8-1:0]   line_data,
    input  logic                      fetch_fault,
    input  logic [FETCH_W-1:0]        slot_is_ctrl,
    input  logic [FETCH_W-1:0]        slot_pred_taken,
    input  logic [FETCH_W*ADDR_W-1:0] slot_pred_tgt,
    input  logic [FETCH_W-1:0]        slot_is_quiesce,
    output logic                      out_valid,
    output logic [FETCH_W-1:0]        out_mask,
    output logic [CW-1:0]             out_count,
    output logic [FETCH_W*IW-1:0]     out_inst,
    output logic [FETCH_W*ADDR_W-1:0] out_pc,
    output logic [FETCH_W*ADDR_W-1:0] out_next_pc,
    output logic [FETCH_W-1:0]        out_taken,
    output logic                      out_fault,
    output logic [ADDR_W-1:0]         cur_pc,
    output logic [ADDR_W-1:0]         cur_npc,
    output logic                      trap_pending,
    output logic                      quiesce_pending,
    output logic [CNT_W-1:0]          cnt_inst,
    output logic [CNT_W-1:0]          cnt_branch,
    output logic [CNT_W-1:0]          cnt_taken
);
    logic [FETCH_W*IW-1:0]     w_word;
    logic [FETCH_W-1:0]        w_in_line;
    logic [FETCH_W-1:0]        k_mask;
    logic [FETCH_W*ADDR_W-1:0] k_pc, k_next;
    logic [FETCH_W-1:0]        k_taken;
    logic [ADDR_W-1:0]         k_fpc, k_fnpc;
    logic                      k_quiesce;
    logic [CW-1:0]             k_emit, k_branch, k_taken_n;
    logic                      accept;

    logic [FETCH_W-1:0]        n_mask;
    logic [CW-1:0]             n_count;
    logic [FETCH_W*IW-1:0]     n_inst, masked_inst;
    logic [FETCH_W*ADDR_W-1:0] n_pc, n_next;
    logic [FETCH_W-1:0]        n_taken;
    logic                      n_fault;
    logic [CW-1:0]             inc_inst, inc_br, inc_tk;

    fge_word_select #(.LINE_BYTES(LINE_BYTES), .FETCH_W(FETCH_W)) u_sel (
        .line_data    (line_data),
        .start_idx    (cur_pc[OFF_W-1:2]),
        .slot_word    (w_word),
        .slot_in_line (w_in_line)
    );

    fge_slot_walker #(.FETCH_W(FETCH_W), .ADDR_W(ADDR_W)) u_walk (
        .pc          (cur_pc),
        .npc         (cur_npc),
        .in_line     (w_in_line),
        .is_ctrl     (slot_is_ctrl),
        .pred_taken  (slot_pred_taken),
        .pred_tgt    (slot_pred_tgt),
        .is_quiesce  (slot_is_quiesce),
        .emit_mask   (k_mask),
        .slot_pc     (k_pc),
        .slot_next   (k_next),
        .slot_taken  (k_taken),
        .final_pc    (k_fpc),
        .final_npc   (k_fnpc),
        .hit_quiesce (k_quiesce),
        .n_emit      (k_emit),
        .n_branch    (k_branch),
        .n_taken     (k_taken_n)
    );

    for (genvar s = 0; s < FETCH_W; s++) begin : g_mask
        assign masked_inst[s*IW +: IW] = k_mask[s] ? w_word[s*IW +: IW] : '0;
    end

    // purpose: a request counts only when no redirect and the thread is not parked
    always_comb accept = grp_req && !redir_valid && !trap_pending && !quiesce_pending;

    // purpose: choose the group to register: fault no-op, walked group or empty
    always_comb begin
        n_mask = '0;
        n_count = '0;
        n_inst = '0;
        n_pc = '0;
        n_next = '0;
        n_taken = '0;
        n_fault = 1'b0;
        inc_inst = '0;
        inc_br = '0;
        inc_tk = '0;
        if (accept && fetch_fault) begin
            n_mask = FETCH_W'(1);
            n_count = CW'(1);
            n_inst[IW-1:0] = NOP_WORD;
            n_pc[ADDR_W-1:0] = cur_pc;
            n_next[ADDR_W-1:0] = cur_npc;
            n_fault = 1'b1;
        end else if (accept) begin
            n_mask = k_mask;
            n_count = k_emit;
            n_inst = masked_inst;
            n_pc = k_pc;
            n_next = k_next;
            n_taken = k_taken;
            inc_inst = k_emit;
            inc_br = k_branch;
            inc_tk = k_taken_n;
        end
    end

    // purpose: register the group outputs for decode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_mask <= '0;
            out_count <= '0;
            out_inst <= '0;
            out_pc <= '0;
            out_next_pc <= '0;
            out_taken <= '0;
            out_fault <= 1'b0;
        end else begin
            out_valid <= accept;
            out_mask <= n_mask;
            out_count <= n_count;
            out_inst <= n_inst;
            out_pc <= n_pc;
            out_next_pc <= n_next;
            out_taken <= n_taken;
            out_fault <= n_fault;
        end
    end

    // purpose: thread PC pair and parking flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_pc <= '0;
            cur_npc <= ADDR_W'(fge_pkg::INST_BYTES);
            trap_pending <= 1'b0;
            quiesce_pending <= 1'b0;
        end else if (redir_valid) begin
            cur_pc <= redir_pc;
            cur_npc <= redir_npc;
            trap_pending <= 1'b0;
            quiesce_pending <= 1'b0;
        end else if (accept && fetch_fault) begin
            trap_pending <= 1'b1;
        end else if (accept) begin
            cur_pc <= k_fpc;
            cur_npc <= k_fnpc;
            if (k_quiesce) quiesce_pending <= 1'b1;
        end
    end

    fge_sat_counter #(.CNT_W(CNT_W), .INC_W(CW)) u_cnt_inst (
        .clk(clk), .rst_n(rst_n), .inc(inc_inst), .count(cnt_inst));
    fge_sat_counter #(.CNT_W(CNT_W), .INC_W(CW)) u_cnt_br (
        .clk(clk), .rst_n(rst_n), .inc(inc_br), .count(cnt_branch));
    fge_sat_counter #(.CNT_W(CNT_W), .INC_W(CW)) u_cnt_tk (
        .clk(clk), .rst_n(rst_n), .inc(inc_tk), .count(cnt_taken));
endmodule

// File: rtl/fge_checker.sv
// Assertions on the fetch group extractor ports, bound to the top module.
module fge_checker #(
    parameter int FETCH_W = 4,
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 16,
    localparam int CW     = $clog2(FETCH_W+1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               redir_valid,
    input logic               out_valid,
    input logic [FETCH_W-1:0] out_mask,
    input logic [CW-1:0]      out_count,
    input logic               out_fault,
    input logic [ADDR_W-1:0]  cur_pc,
    input logic               trap_pending,
    input logic               quiesce_pending,
    input logic [CNT_W-1:0]   cnt_inst
);
    AST_MASK_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_mask & (out_mask + FETCH_W'(1))) == '0)); // R11
    AST_MASK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(out_mask) == int'(out_count))); // R11
    AST_GROUP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_count != '0)); // R3
    AST_FAULT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fault) |-> (out_count == CW'(1) && trap_pending)); // R7
    AST_FAULT_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fault) |-> (cur_pc == $past(cur_pc))); // R7
    AST_PARKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((trap_pending || quiesce_pending) && !redir_valid) |=> !out_valid); // R9
    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_mask == '0 && !out_fault)); // R11
    AST_CNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_inst >= $past(cnt_inst)); // R10
endmodule

bind fetch_group_extractor fge_checker #(
    .FETCH_W(FETCH_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_fge_checker (
    .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .out_valid(out_valid),
    .out_mask(out_mask), .out_count(out_count), .out_fault(out_fault),
    .cur_pc(cur_pc), .trap_pending(trap_pending),
    .quiesce_pending(quiesce_pending), .cnt_inst(cnt_inst)
);

// File: tb/fetch_group_extractor_bench.sv
module fetch_group_extractor_bench;
    localparam int LB = 32;
    localparam int FW = 4;
    localparam int AW = 32;
    localparam int CNW = 6;
    localparam int WORDS = LB / 4;
    localparam int CW = $clog2(FW+1);
    localparam logic [31:0] NOP = 32'h0000_0013;
    localparam logic [CNW-1:0] CMAX = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic              redir_valid = 0;
    logic [AW-1:0]     redir_pc = 0, redir_npc = 0;
    logic              grp_req = 0, fetch_fault = 0;
    logic [LB*8-1:0]   line_data;
    logic [FW-1:0]     s_ctrl = 0, s_tk = 0, s_qu = 0;
    logic [FW*AW-1:0]  s_tgt = 0;
    logic [31:0]       lw [WORDS];

    logic              out_valid, out_fault, trap_pending, quiesce_pending;
    logic [FW-1:0]     out_mask, out_taken;
    logic [CW-1:0]     out_count;
    logic [FW*32-1:0]  out_inst;
    logic [FW*AW-1:0]  out_pc, out_next_pc;
    logic [AW-1:0]     cur_pc, cur_npc;
    logic [CNW-1:0]    cnt_inst, cnt_branch, cnt_taken;

    always_comb for (int j = 0; j < WORDS; j++) line_data[j*32 +: 32] = lw[j];

    fetch_group_extractor #(.LINE_BYTES(LB), .FETCH_W(FW), .ADDR_W(AW),
                            .CNT_W(CNW), .NOP_WORD(NOP)) u_fetch_group_extractor (
        .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_pc(redir_pc),
        .redir_npc(redir_npc), .grp_req(grp_req), .line_data(line_data),
        .fetch_fault(fetch_fault), .slot_is_ctrl(s_ctrl), .slot_pred_taken(s_tk),
        .slot_pred_tgt(s_tgt), .slot_is_quiesce(s_qu), .out_valid(out_valid),
        .out_mask(out_mask), .out_count(out_count), .out_inst(out_inst),
        .out_pc(out_pc), .out_next_pc(out_next_pc), .out_taken(out_taken),
        .out_fault(out_fault), .cur_pc(cur_pc), .cur_npc(cur_npc),
        .trap_pending(trap_pending), .quiesce_pending(quiesce_pending),
        .cnt_inst(cnt_inst), .cnt_branch(cnt_branch), .cnt_taken(cnt_taken));

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [AW-1:0] m_pc = 0, m_npc = 4;
    logic m_tp = 0, m_qp = 0, e_valid = 0, e_fault = 0;
    int m_ci = 0, m_cb = 0, m_ct = 0, e_count = 0;
    logic [FW-1:0] e_mask = 0, e_tk = 0;
    logic [31:0] e_inst [FW];
    logic [AW-1:0] e_pc [FW];
    logic [AW-1:0] e_nx [FW];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int sat(input int v);
        return (v > int'(CMAX)) ? int'(CMAX) : v;
    endfunction

    task automatic model();
        logic [AW-1:0] cur, cn, nx, nn;
        int idx, br, tk, cnt;
        logic alive;
        e_valid = 0; e_fault = 0; e_count = 0; e_mask = 0; e_tk = 0;
        for (int i = 0; i < FW; i++) begin e_inst[i] = 0; e_pc[i] = 0; e_nx[i] = 0; end
        if (redir_valid) begin
            m_pc = redir_pc; m_npc = redir_npc; m_tp = 0; m_qp = 0;
        end else if (grp_req && !m_tp && !m_qp) begin
            e_valid = 1;
            if (fetch_fault) begin
                e_fault = 1; e_count = 1; e_mask = 1;
                e_inst[0] = NOP; e_pc[0] = m_pc; e_nx[0] = m_npc; m_tp = 1;
            end else begin
                idx = int'(m_pc % LB) / 4;
                cur = m_pc; cn = m_npc; alive = 1; br = 0; tk = 0; cnt = 0;
                for (int i = 0; i < FW; i++) begin
                    if (alive && idx + i < WORDS) begin
                        if (s_ctrl[i]) begin
                            nx = s_tk[i] ? s_tgt[i*AW +: AW] : cur + 4;
                            nn = nx + 4; br++;
                            if (s_tk[i]) tk++;
                            e_tk[i] = s_tk[i];
                        end else begin
                            nx = cn; nn = cn + 4;
                        end
                        e_inst[i] = lw[idx + i]; e_pc[i] = cur; e_nx[i] = nx;
                        e_mask[i] = 1; cnt++;
                        if (s_qu[i]) m_qp = 1;
                        alive = (nx == cur + 4) && !s_qu[i];
                        cur = nx; cn = nn;
                    end else alive = 0;
                end
                m_pc = cur; m_npc = cn; e_count = cnt;
                m_ci = sat(m_ci + cnt); m_cb = sat(m_cb + br); m_ct = sat(m_ct + tk);
            end
        end
    endtask

    task automatic compare();
        chk("R9 valid", 32'(out_valid), 32'(e_valid));
        chk("R11 count", 32'(out_count), 32'(e_count));
        chk("R11 mask", 32'(out_mask), 32'(e_mask));
        chk("R7 fault", 32'(out_fault), 32'(e_fault));
        chk("R6 pc", cur_pc, m_pc);
        chk("R6 npc", cur_npc, m_npc);
        chk("R7 trap", 32'(trap_pending), 32'(m_tp));
        chk("R8 quiesce", 32'(quiesce_pending), 32'(m_qp));
        chk("R10 inst", 32'(cnt_inst), 32'(m_ci));
        chk("R10 branch", 32'(cnt_branch), 32'(m_cb));
        chk("R10 taken", 32'(cnt_taken), 32'(m_ct));
        for (int i = 0; i < FW; i++) begin
            chk("R2 inst", out_inst[i*32 +: 32], e_inst[i]);
            chk("R2 slot pc", out_pc[i*AW +: AW], e_pc[i]);
            chk("R5 next", out_next_pc[i*AW +: AW], e_nx[i]);
            chk("R4 taken", 32'(out_taken[i]), 32'(e_tk[i]));
        end
    endtask

    // one clock: model, edge, sample away from the edge, clear inputs
    task automatic step();
        model();
        @(posedge clk);
        #2;
        compare();
        redir_valid = 0; grp_req = 0; fetch_fault = 0;
        s_ctrl = 0; s_tk = 0; s_qu = 0; s_tgt = 0;
    endtask

    task automatic redirect(input logic [AW-1:0] p, input logic [AW-1:0] n);
        redir_valid = 1; redir_pc = p; redir_npc = n;
        step();
    endtask

    initial begin
        for (int j = 0; j < WORDS; j++) lw[j] = 32'hA000_0000 + 32'(j);
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        chk("R1 pc", cur_pc, 0);
        chk("R1 npc", cur_npc, 4);
        chk("R1 valid", 32'(out_valid), 0);
        chk("R1 mask", 32'(out_mask), 0);
        chk("R1 count", 32'(out_count), 0);
        chk("R1 pend", 32'({trap_pending, quiesce_pending}), 0);
        chk("R1 cnt", 32'({cnt_inst, cnt_branch, cnt_taken}), 0);
        rst_n = 1;

        // R3 fetch width limit
        redirect(32'h100, 32'h104);
        grp_req = 1; step();
        chk("R3 width", 32'(out_count), 4);
        chk("R6 pc after width", cur_pc, 32'h110);

        // R3 line end limit
        redirect(32'h118, 32'h11C);
        grp_req = 1; step();
        chk("R3 line end", 32'(out_count), 2);

        // R2 start offset
        redirect(32'h10C, 32'h110);
        grp_req = 1; step();
        chk("R2 first slot pc", out_pc[AW-1:0], 32'h10C);
        chk("R2 first word", out_inst[31:0], lw[3]);

        // R5 taken branch ends group
        redirect(32'h100, 32'h104);
        s_ctrl = 4'b0011; s_tk = 4'b0010; s_tgt[1*AW +: AW] = 32'h400;
        grp_req = 1; step();
        chk("R5 count", 32'(out_count), 2);
        chk("R5 pc", cur_pc, 32'h400);

        // R4 non-sequential NPC
        redirect(32'h100, 32'h180);
        grp_req = 1; step();
        chk("R4 count", 32'(out_count), 1);
        chk("R4 pc", cur_pc, 32'h180);

        // taken branch on last line word, at full width
        redirect(32'h110, 32'h114);
        s_ctrl = 4'b1000; s_tk = 4'b1000; s_tgt[3*AW +: AW] = 32'h800;
        grp_req = 1; step();
        chk("R3 coincide", 32'(out_count), 4);

        // R8 quiesce, then R9 request ignored
        redirect(32'h100, 32'h104);
        s_qu = 4'b0100; grp_req = 1; step();
        chk("R8 count", 32'(out_count), 3);
        chk("R8 flag", 32'(quiesce_pending), 1);
        grp_req = 1; step();
        chk("R9 parked", 32'(out_valid), 0);

        // R7 fault, then R9 ignored
        redirect(32'h100, 32'h104);
        fetch_fault = 1; grp_req = 1; step();
        chk("R7 nop", out_inst[31:0], NOP);
        chk("R7 pc kept", cur_pc, 32'h100);
        grp_req = 1; step();
        chk("R9 trap parked", 32'(out_valid), 0);

        // R9 redirect wins over a request
        redir_valid = 1; redir_pc = 32'h200; redir_npc = 32'h204; grp_req = 1; step();
        chk("R9 redirect wins", 32'(out_valid), 0);

        // R10 saturation
        redirect(32'h0, 32'h4);
        for (int k = 0; k < 20; k++) begin
            s_ctrl = 4'b0001; grp_req = 1; step();
        end
        chk("R10 saturate", 32'(cnt_inst), 32'(CMAX));

        // random mix
        for (int k = 0; k < 3000; k++) begin
            for (int j = 0; j < WORDS; j++) lw[j] = $urandom;
            if ($urandom_range(9) == 0) begin
                redir_valid = 1;
                redir_pc = {$urandom_range(4095), 2'b00};
                redir_npc = ($urandom_range(3) == 0) ? {$urandom_range(4095), 2'b00}
                                                     : redir_pc + 4;
            end
            grp_req = ($urandom_range(9) < 7);
            fetch_fault = ($urandom_range(14) == 0);
            s_ctrl = 4'($urandom); s_tk = 4'($urandom);
            s_qu = ($urandom_range(19) == 0) ? 4'($urandom) : 4'b0;
            for (int i = 0; i < FW; i++) s_tgt[i*AW +: AW] = {$urandom_range(4095), 2'b00};
            step();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule